// File: doc/BRIEF.md
# Interrupt Running Priority Tracker

This block follows the running priority of a single CPU interrupt interface. A stream of events comes in from the interrupt handling logic: an interrupt becomes active, an active interrupt has its priority dropped, or the most recently activated interrupt is deactivated. Each event carries an 8-bit priority, a flag that marks a non-maskable interrupt (NMI), and a tag that says whether the interrupt belongs to the non-secure or the secure group 1. The block keeps the active interrupts in a last-in, first-out stack of up to `DEPTH` entries. An entry stays on the stack after its priority drop until it is deactivated.

From the entries that are active and not yet dropped, the block forms the 64-bit value a reader sees. The low byte holds the group priority of the most urgent entry. Two high bits report NMI activity. The reader's security view and a single-security mode input decide how NMIs are ranked and what is shown. The value is combinational from the stack state and the two read-side inputs, so an event is visible in the cycle after the clock edge that accepts it.

Top module: `rpr_tracker`

## Requirements
- R1: After a synchronous active-low reset the stack is empty, `rpr_value` reads 0x00000000000000FF in every view and mode, and `ovf_err` is 0.
- R2: Bits 61:8 of `rpr_value` are always zero, and bits 7:0 carry the running priority.
- R3: The stack holds `DEPTH` (default 16) entries. An activate event that arrives while the stack is full is ignored and leaves the stack unchanged. `ovf_err` is 1 for exactly the cycle after that event and 0 after every other event.
- R4: The running priority is the smallest group priority among the live entries (active and not dropped). For a non-NMI entry the group priority is its priority with bit 0 cleared and with every bit below the `PRIO_BITS` implemented bits cleared.
- R5: When no entry is live, bits 7:0 read 0xFF whatever `PRIO_BITS` is, so the idle value does not reveal the number of implemented bits.
- R6: `evt_kind` encodes 0 = none, 1 = activate (push), 2 = drop, 3 = deactivate. A drop marks the most recently pushed live entry as dropped. A deactivate pops the top entry, whether or not it has been dropped. A drop with no live entry, or a deactivate on an empty stack, has no effect.
- R7: An NMI entry ranks at 0x00 when it is secure (`evt_ns` = 0) or when `single_sec` = 1. A non-secure NMI ranks at 0x80 when `single_sec` = 0. In that case a non-secure reader (`rd_view` = 0) sees 0x00 whenever the running priority is 0x80.
- R8: `rd_view` encodes 0 = non-secure, 1 = secure, 2 = realm, 3 = root. Bit 62 reads 0 for views 0 and 2. For views 1 and 3 it is 1 exactly while a live non-secure NMI exists.
- R9: Bit 63 is 1 exactly while a live NMI of the reader's kind exists. With `single_sec` = 1 that is any NMI. With `single_sec` = 0, views 0 and 2 count non-secure NMIs and views 1 and 3 count secure NMIs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | Event present this cycle |
| evt_kind | input | 2 | Event type: 0 none, 1 activate, 2 drop, 3 deactivate |
| evt_prio | input | 8 | Priority of the activated interrupt |
| evt_nmi | input | 1 | Activated interrupt is an NMI |
| evt_ns | input | 1 | Activated interrupt is non-secure group 1 (0 = secure group 1) |
| rd_view | input | 2 | Reader security view: 0 non-secure, 1 secure, 2 realm, 3 root |
| single_sec | input | 1 | Single-security mode |
| rpr_value | output | 64 | Value seen by the reader |
| ovf_err | output | 1 | Activate was refused because the stack was full |

## Verification
A wrong stack pointer or a misplaced drop mark shows up on the low byte of `rpr_value` in the very next cycle, either as a stale priority or as a missing return to 0xFF. It can hide only while a more urgent entry masks it, so the sequences unwind the stack completely. The NMI ranking and the view masking act combinationally on every read. Any error in them therefore appears as soon as `rd_view` or `single_sec` is swept with an NMI live, and every check walks all eight combinations of these two inputs. An overflow that corrupts the top entry becomes visible when that entry is popped.

// File: rtl/rpr_pkg.sv
// Shared types and constants for the running priority tracker.
// Assumes 8-bit priorities, with lower values being more urgent.
package rpr_pkg;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_ACT   = 2'd1,
        EV_DROP  = 2'd2,
        EV_DEACT = 2'd3
    } evt_kind_e;

    typedef enum logic [1:0] {
        VW_NS    = 2'd0,
        VW_SEC   = 2'd1,
        VW_REALM = 2'd2,
        VW_ROOT  = 2'd3
    } view_e;

    typedef struct packed {
        logic [7:0] prio;
        logic       nmi;
        logic       ns;
        logic       dropped;
    } slot_t;

    localparam logic [7:0] IDLE_PRIO   = 8'hFF;
    localparam logic [7:0] NS_NMI_RANK = 8'h80;
    localparam logic [7:0] TOP_RANK    = 8'h00;

endpackage

// File: rtl/rpr_stack.sv
// Active interrupt stack. It pushes on activate, marks the newest live
// entry on drop, and pops the top entry on deactivate.
// Assumes at most one event per cycle. A push into a full stack is refused
// and reported through ovf_o for one cycle.
module rpr_stack
    import rpr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   evt_valid_i,
    input  logic [1:0]             evt_kind_i,
    input  logic [7:0]             evt_prio_i,
    input  logic                   evt_nmi_i,
    input  logic                   evt_ns_i,
    output slot_t [DEPTH-1:0]      slot_o,
    output logic  [DEPTH-1:0]      live_o,
    output logic                   ovf_o
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    slot_t [DEPTH-1:0] slot_q;
    logic  [CW-1:0]    count_q;
    logic              ovf_q;
    logic              drop_hit;
    logic  [IW-1:0]    drop_idx;
    logic  [IW-1:0]    wr_idx;
    logic  [IW-1:0]    top_idx;
    evt_kind_e         kind;

    assign kind    = evt_kind_e'(evt_kind_i);
    assign wr_idx  = count_q[IW-1:0];
    assign top_idx = wr_idx - 1'b1;

    // Find the newest entry that is occupied and not yet dropped.
    always_comb begin
        drop_hit = 1'b0;
        drop_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if ((CW'(i) < count_q) && !slot_q[i].dropped) begin
                drop_hit = 1'b1;
                drop_idx = IW'(i);
            end
        end
    end

    // Apply one event to the stack and to the overflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q  <= '0;
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            if (evt_valid_i) begin
                case (kind)
                    EV_ACT: begin
                        if (count_q == FULL) begin
                            ovf_q <= 1'b1;
                        end else begin
                            slot_q[wr_idx] <= '{prio: evt_prio_i, nmi: evt_nmi_i,
                                               ns: evt_ns_i, dropped: 1'b0};
                            count_q <= count_q + 1'b1;
                        end
                    end
                    EV_DROP: begin
                        if (drop_hit) begin
                            slot_q[drop_idx].dropped <= 1'b1;
                        end
                    end
                    EV_DEACT: begin
                        if (count_q != '0) begin
                            slot_q[top_idx] <= '0;
                            count_q <= count_q - 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Mark each slot that takes part in the running priority.
    for (genvar g = 0; g < DEPTH; g++) begin : g_live
        assign live_o[g] = (CW'(g) < count_q) && !slot_q[g].dropped;
    end

    assign slot_o = slot_q;
    assign ovf_o  = ovf_q;

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= FULL);

    p_push_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_i && kind == EV_ACT && count_q != FULL)
        |=> (count_q == $past(count_q) + 1'b1));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_i && kind == EV_ACT && count_q == FULL)
        |=> (ovf_o && count_q == FULL));

    p_pop_shrinks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_i && kind == EV_DEACT && count_q != '0)
        |=> (count_q == $past(count_q) - 1'b1));

endmodule

// File: rtl/rpr_slot_rank.sv
// Group priority (rank) of one stack slot. An NMI ranks at a fixed value
// that depends on its group and on the security mode. Any other interrupt
// keeps only its implemented group bits, as with the smallest binary point.
module rpr_slot_rank
    import rpr_pkg::*;
#(
    parameter int PRIO_BITS = 8
) (
    input  slot_t       slot_i,
    input  logic        single_sec_i,
    output logic [7:0]  rank_o
);

    localparam logic [7:0] IMPL_MASK = 8'hFF << (8 - PRIO_BITS);
    localparam logic [7:0] GRP_MASK  = IMPL_MASK & 8'hFE;

    // Choose between the fixed NMI rank and the masked priority.
    always_comb begin
        if (slot_i.nmi) begin
            rank_o = (slot_i.ns && !single_sec_i) ? NS_NMI_RANK : TOP_RANK;
        end else begin
            rank_o = slot_i.prio & GRP_MASK;
        end
    end

endmodule

// File: rtl/rpr_select.sv
// Reduces the per-slot ranks of the live slots to the smallest rank, and
// collects the NMI presence flags by group.
// Assumes the ranks never reach 0xFF, so 0xFF is free to mean idle.
module rpr_select
    import rpr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic [DEPTH-1:0][7:0] rank_i,
    input  slot_t [DEPTH-1:0]     slot_i,
    input  logic [DEPTH-1:0]      live_i,
    output logic [7:0]            run_prio_o,
    output logic                  any_live_o,
    output logic                  nmi_any_o,
    output logic                  nmi_ns_o,
    output logic                  nmi_s_o
);

    // Scan the live slots for the minimum rank and the NMI groups.
    always_comb begin
        run_prio_o = IDLE_PRIO;
        nmi_any_o  = 1'b0;
        nmi_ns_o   = 1'b0;
        nmi_s_o    = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (live_i[i]) begin
                if (rank_i[i] < run_prio_o) begin
                    run_prio_o = rank_i[i];
                end
                if (slot_i[i].nmi) begin
                    nmi_any_o = 1'b1;
                    if (slot_i[i].ns) begin
                        nmi_ns_o = 1'b1;
                    end else begin
                        nmi_s_o = 1'b1;
                    end
                end
            end
        end
    end

    assign any_live_o = |live_i;

endmodule

// File: rtl/rpr_view.sv
// Formats the 64-bit read value for the reader's security view. It
// saturates the non-secure NMI rank for non-secure readers and masks the
// NMI status bits per view.
module rpr_view
    import rpr_pkg::*;
(
    input  logic [7:0]  run_prio_i,
    input  logic        any_live_i,
    input  logic        nmi_any_i,
    input  logic        nmi_ns_i,
    input  logic        nmi_s_i,
    input  logic [1:0]  rd_view_i,
    input  logic        single_sec_i,
    output logic [63:0] value_o
);

    view_e      view;
    logic       secure_side;
    logic [7:0] prio_shown;
    logic       nmi_bit;
    logic       ns_nmi_bit;

    assign view        = view_e'(rd_view_i);
    assign secure_side = (view == VW_SEC) || (view == VW_ROOT);

    // Pick the priority byte, with non-secure saturation of the NMI rank.
    always_comb begin
        if (!any_live_i) begin
            prio_shown = IDLE_PRIO;
        end else if (view == VW_NS && !single_sec_i && nmi_ns_i
                     && run_prio_i == NS_NMI_RANK) begin
            prio_shown = TOP_RANK;
        end else begin
            prio_shown = run_prio_i;
        end
    end

    // Select which NMI group each status bit reports for this view.
    always_comb begin
        if (single_sec_i) begin
            nmi_bit = nmi_any_i;
        end else begin
            nmi_bit = secure_side ? nmi_s_i : nmi_ns_i;
        end
        ns_nmi_bit = secure_side && nmi_ns_i;
    end

    assign value_o = {nmi_bit, ns_nmi_bit, 54'd0, prio_shown};

endmodule

// File: rtl/rpr_tracker.sv
// Top of the running priority tracker: stack, per-slot rank, minimum
// reduction and view formatting.
// Assumes the event source issues at most one event per cycle and only
// deactivates interrupts in reverse order of activation.
module rpr_tracker
    import rpr_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int PRIO_BITS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        evt_valid,
    input  logic [1:0]  evt_kind,
    input  logic [7:0]  evt_prio,
    input  logic        evt_nmi,
    input  logic        evt_ns,
    input  logic [1:0]  rd_view,
    input  logic        single_sec,
    output logic [63:0] rpr_value,
    output logic        ovf_err
);

    slot_t [DEPTH-1:0]     slot;
    logic  [DEPTH-1:0]     live;
    logic  [DEPTH-1:0][7:0] rank;
    logic  [7:0]           run_prio;
    logic                  any_live;
    logic                  nmi_any;
    logic                  nmi_ns;
    logic                  nmi_s;
    logic  [DEPTH-1:0]     live_nmi;

    rpr_stack #(.DEPTH(DEPTH)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_valid_i (evt_valid),
        .evt_kind_i  (evt_kind),
        .evt_prio_i  (evt_prio),
        .evt_nmi_i   (evt_nmi),
        .evt_ns_i    (evt_ns),
        .slot_o      (slot),
        .live_o      (live),
        .ovf_o       (ovf_err)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_rank
        rpr_slot_rank #(.PRIO_BITS(PRIO_BITS)) u_rank (
            .slot_i       (slot[g]),
            .single_sec_i (single_sec),
            .rank_o       (rank[g])
        );
        assign live_nmi[g] = live[g] && slot[g].nmi;
    end

    rpr_select #(.DEPTH(DEPTH)) u_select (
        .rank_i     (rank),
        .slot_i     (slot),
        .live_i     (live),
        .run_prio_o (run_prio),
        .any_live_o (any_live),
        .nmi_any_o  (nmi_any),
        .nmi_ns_o   (nmi_ns),
        .nmi_s_o    (nmi_s)
    );

    rpr_view u_view (
        .run_prio_i   (run_prio),
        .any_live_i   (any_live),
        .nmi_any_i    (nmi_any),
        .nmi_ns_i     (nmi_ns),
        .nmi_s_i      (nmi_s),
        .rd_view_i    (rd_view),
        .single_sec_i (single_sec),
        .value_o      (rpr_value)
    );

    p_idle_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (live == '0) |-> (rpr_value[7:0] == IDLE_PRIO && rpr_value[63:62] == 2'b00));

    p_grp_lsb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (live != '0) |-> !rpr_value[0]);

    p_ns_hidden_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_view == 2'd0 || rd_view == 2'd2) |-> !rpr_value[62]);

    p_nmi_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rpr_value[63] |-> (live_nmi != '0));

    p_ss_nmi_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (single_sec && live_nmi != '0) |-> (rpr_value[7:0] == TOP_RANK));

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rpr_value[61:8] == 54'd0);

endmodule

// File: tb/rpr_tracker_bench.sv
module rpr_tracker_bench;

    localparam int CLK_PERIOD = 20;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [1:0]  evt_kind = 2'd0;
    logic [7:0]  evt_prio = 8'd0;
    logic        evt_nmi = 1'b0;
    logic        evt_ns = 1'b0;
    logic [1:0]  rd_view = 2'd0;
    logic        single_sec = 1'b0;
    logic [63:0] rpr_value;
    logic        ovf_err;

    int total = 0;
    int bad   = 0;

    logic [7:0] m_prio [DEPTH];
    logic       m_nmi  [DEPTH];
    logic       m_ns   [DEPTH];
    logic       m_drop [DEPTH];
    int         m_cnt = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rpr_tracker u_rpr_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_valid  (evt_valid),
        .evt_kind   (evt_kind),
        .evt_prio   (evt_prio),
        .evt_nmi    (evt_nmi),
        .evt_ns     (evt_ns),
        .rd_view    (rd_view),
        .single_sec (single_sec),
        .rpr_value  (rpr_value),
        .ovf_err    (ovf_err)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s view=%0d ss=%0b got=%h exp=%h", req, rd_view, single_sec, got, exp);
        end
    endtask

    // Expected read value from the requirements (R2, R4, R5, R7, R8, R9).
    function automatic logic [63:0] exp_val(input int v, input bit ss);
        logic [7:0] best = 8'hFF;
        logic [7:0] g;
        bit any = 0, nmi_any = 0, nmi_ns = 0, nmi_s = 0, sec_side;
        for (int i = 0; i < m_cnt; i++) begin
            if (!m_drop[i]) begin
                if (m_nmi[i]) g = (m_ns[i] && !ss) ? 8'h80 : 8'h00;
                else          g = m_prio[i] & 8'hFE;
                if (g < best) best = g;
                any = 1;
                if (m_nmi[i]) begin
                    nmi_any = 1;
                    if (m_ns[i]) nmi_ns = 1; else nmi_s = 1;
                end
            end
        end
        if (!any) best = 8'hFF;
        if (v == 0 && !ss && nmi_ns && best == 8'h80) best = 8'h00;
        sec_side = (v == 1) || (v == 3);
        return {(ss ? nmi_any : (sec_side ? nmi_s : nmi_ns)), (sec_side && nmi_ns), 54'd0, best};
    endfunction

    task automatic check_all(input string req);
        for (int ss = 0; ss < 2; ss++) begin
            for (int v = 0; v < 4; v++) begin
                single_sec = ss[0];
                rd_view = v[1:0];
                #1;
                chk(req, rpr_value, exp_val(v, ss[0]));
            end
        end
    endtask

    // Issue one event, update the model, and check ovf_err and every view.
    task automatic evt(input string req, input logic [1:0] k, input logic [7:0] p,
                       input logic n, input logic s);
        bit exp_ovf = 0;
        bit found = 0;
        evt_valid = 1'b1; evt_kind = k; evt_prio = p; evt_nmi = n; evt_ns = s;
        case (k)
            2'd1: begin
                if (m_cnt == DEPTH) exp_ovf = 1;
                else begin
                    m_prio[m_cnt] = p; m_nmi[m_cnt] = n; m_ns[m_cnt] = s;
                    m_drop[m_cnt] = 0; m_cnt++;
                end
            end
            2'd2: begin
                for (int i = m_cnt - 1; i >= 0; i--) begin
                    if (!found && !m_drop[i]) begin m_drop[i] = 1; found = 1; end
                end
            end
            2'd3: if (m_cnt > 0) m_cnt--;
            default: ;
        endcase
        @(posedge clk);
        #1;
        evt_valid = 1'b0;
        evt_kind = 2'd0;
        chk({req, " ovf"}, {63'd0, ovf_err}, {63'd0, exp_ovf});
        check_all(req);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog got=timeout exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] lf = 16'hACE1;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 ovf", {63'd0, ovf_err}, 64'd0);
        check_all("R1");

        // R4 / R5 / R2: every priority alone, then pop back to idle
        for (int p = 0; p < 256; p++) begin
            evt("R4", 2'd1, p[7:0], 1'b0, p[0]);
            evt("R5", 2'd3, 8'd0, 1'b0, 1'b0);
        end

        // R7 / R8 / R9: NMI ranking and status bits by group
        evt("R7", 2'd1, 8'hC0, 1'b0, 1'b1);
        evt("R7", 2'd1, 8'h44, 1'b1, 1'b1);
        evt("R8", 2'd1, 8'h90, 1'b0, 1'b0);
        evt("R9", 2'd1, 8'h22, 1'b1, 1'b0);
        evt("R9", 2'd2, 8'd0, 1'b0, 1'b0);
        evt("R8", 2'd2, 8'd0, 1'b0, 1'b0);
        evt("R7", 2'd2, 8'd0, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) evt("R6", 2'd3, 8'd0, 1'b0, 1'b0);
        evt("R7", 2'd1, 8'h80, 1'b0, 1'b1);
        evt("R7", 2'd1, 8'h10, 1'b1, 1'b1);
        evt("R7", 2'd3, 8'd0, 1'b0, 1'b0);
        evt("R7", 2'd3, 8'd0, 1'b0, 1'b0);

        // R6: drop order, pop of dropped entries, empty-stack no-ops
        evt("R6", 2'd1, 8'h60, 1'b0, 1'b1);
        evt("R6", 2'd1, 8'h40, 1'b0, 1'b1);
        evt("R6", 2'd1, 8'h20, 1'b0, 1'b0);
        evt("R6", 2'd2, 8'd0, 1'b0, 1'b0);
        evt("R6", 2'd2, 8'd0, 1'b0, 1'b0);
        evt("R6", 2'd1, 8'h30, 1'b0, 1'b1);
        evt("R6", 2'd2, 8'd0, 1'b0, 1'b0);
        evt("R6", 2'd3, 8'd0, 1'b0, 1'b0);
        evt("R6", 2'd3, 8'd0, 1'b0, 1'b0);
        evt("R6", 2'd2, 8'd0, 1'b0, 1'b0);
        evt("R6", 2'd2, 8'd0, 1'b0, 1'b0);
        evt("R6", 2'd3, 8'd0, 1'b0, 1'b0);
        evt("R6", 2'd3, 8'd0, 1'b0, 1'b0);
        evt("R6", 2'd3, 8'd0, 1'b0, 1'b0);
        evt("R6", 2'd0, 8'h05, 1'b1, 1'b0);
        evt("R6", 2'd1, 8'h10, 1'b0, 1'b0);
        evt("R6", 2'd3, 8'd0, 1'b0, 1'b0);

        // R3: fill the stack, overflow, then unwind to idle
        for (int i = 0; i < DEPTH; i++) evt("R3", 2'd1, 8'(8'hF0 - 8 * i), 1'b0, 1'b1);
        evt("R3", 2'd1, 8'h02, 1'b1, 1'b0);
        evt("R3", 2'd0, 8'd0, 1'b0, 1'b0);
        for (int i = 0; i < DEPTH; i++) evt("R3", 2'd3, 8'd0, 1'b0, 1'b0);

        // R4 / R6 / R9: pseudo-random event mix against the model
        for (int n = 0; n < 600; n++) begin
            logic [1:0] k;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            k = (lf[1:0] == 2'd0) ? 2'd2 : (lf[2] ? 2'd1 : 2'd3);
            if (lf[4:3] == 2'd0) k = 2'd1;
            evt("R4", k, lf[15:8], (lf[7:5] == 3'd0), lf[6]);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule